// File: doc/BRIEF.md
# Subtract-and-Branch Processor Core

This core runs programs built from one instruction. Each instruction takes three consecutive memory words: a source operand address, a destination operand address and a branch target. The core subtracts the source value from the destination value and writes the difference back to the destination. It then either moves on to the next instruction three words later or jumps to the target. The carry out of the subtractor alone makes that choice. No sign or zero flag exists.

The core has one synchronous memory port. Read data returns one cycle after the address. The core steps through seven cycles per instruction: three word fetches, two operand reads, a write-back and a branch step. Operand and target words are data-width values. The core sign-extends them to the address width, so small negative numbers reach the top of the address space. The two highest addresses hold the I/O ports. The highest address reads the input port. The next one down is the output port. That port reads as all ones, so a program writes to it through the usual read-modify-write, and the port stores the inverse of the written word. A branch to the all-ones address stops the core until reset.

Top module: `oisc_core`

## Requirements
- R1: After reset, each instruction takes exactly seven cycles. The memory address shows PC, PC+1, PC+2, then the source address, then the destination address for two cycles, then a branch cycle. All address arithmetic wraps modulo 2^ADDR_W.
- R2: Each fetched address or target word is sign-extended from DATA_W to ADDR_W bits. For example, the 8-bit word 0xFE becomes the 12-bit address 0xFFE.
- R3: In the sixth cycle of an instruction, the write data equals the destination value minus the source value, modulo 2^DATA_W.
- R4: The next PC is PC+3 when the destination value is strictly greater than the source value, compared unsigned. Otherwise, including when the two are equal, the next PC is the target.
- R5: While reset is active, the address is 0, no write is issued, the output port is 0 and the halted flag is low. A program made of the words 0 0 0 keeps fetching from address 0.
- R6: A read of the all-ones address returns in_port, not memory data. A write aimed at that address does not raise mem_we.
- R7: A read of the all-ones-minus-one address returns all ones. A write aimed at it does not raise mem_we. From the next cycle, out_port holds the bitwise inverse of the write data.
- R8: A branch taken to the all-ones target raises halted in the cycle after the branch cycle. Halted then stays high until reset, with no memory write and no change on out_port.
- R9: mem_we is high for at most one cycle per instruction, always the sixth. It is high only when the destination is not an I/O address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after the address |
| mem_we | output | 1 | Memory write enable |
| in_port | input | DATA_W | Input port value, read at the all-ones address |
| out_port | output | DATA_W | Output port register |
| halted | output | 1 | High once the core has stopped |

## Verification
The output-port capture and the halt decision both come from the same subtractor result in the same write-back cycle. A mistake in one can therefore hide behind the other. The test program ends with an instruction whose destination is the output port and whose target is the all-ones address. The two operands are equal, so the branch is taken. A cycle-accurate behavioural model then expects out_port to show the inverted difference in the branch cycle, and halted to rise one cycle later with no further writes. The other instructions cover the advance case, the equal case, a borrow case and a read of the input port.

// File: rtl/oisc_pkg.sv
package oisc_pkg;
   typedef enum logic [2:0] {
      ST_FETCH_A = 3'd0,
      ST_FETCH_B = 3'd1,
      ST_FETCH_C = 3'd2,
      ST_READ_A  = 3'd3,
      ST_READ_B  = 3'd4,
      ST_WRITE_B = 3'd5,
      ST_BRANCH  = 3'd6,
      ST_HALT    = 3'd7
   } oisc_state_e;
endpackage

// File: rtl/oisc_subtract.sv
module oisc_subtract #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] minuend,
   input  logic [DATA_W-1:0] subtrahend,
   output logic [DATA_W-1:0] diff,
   output logic              gt
);
   // minuend + ~subtrahend carries out exactly when minuend > subtrahend
   logic [DATA_W:0] part;
   assign part = {1'b0, minuend} + {1'b0, ~subtrahend};
   assign gt   = part[DATA_W];
   assign diff = part[DATA_W-1:0] + DATA_W'(1);
endmodule

// File: rtl/oisc_pc_adder.sv
module oisc_pc_adder #(
   parameter int ADDR_W = 12,
   parameter int STEP   = 3
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic              cin,
   output logic [ADDR_W-1:0] pc_next
);
   localparam logic [ADDR_W-1:0] OFFSET = ADDR_W'(STEP - 1);
   assign pc_next = pc + OFFSET + {{(ADDR_W-1){1'b0}}, cin};
endmodule

// File: rtl/oisc_io_port.sv
module oisc_io_port #(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 8,
   parameter bit INVERT_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] in_port,
   output logic              mem_we,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] out_port
);
   localparam logic [ADDR_W-1:0] IN_ADDR  = '1;
   localparam logic [ADDR_W-1:0] OUT_ADDR = {{(ADDR_W-1){1'b1}}, 1'b0};

   logic hit_in, hit_out, sel_in_q, sel_out_q;
   logic [DATA_W-1:0] cap, out_q;

   assign hit_in  = (addr == IN_ADDR);
   assign hit_out = (addr == OUT_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_in_q  <= 1'b0;
         sel_out_q <= 1'b0;
      end else begin
         sel_in_q  <= hit_in;
         sel_out_q <= hit_out;
      end
   end

   assign rdata  = sel_in_q ? in_port : (sel_out_q ? '1 : mem_rdata);
   assign mem_we = wr_req & ~hit_in & ~hit_out;

   generate
      if (INVERT_OUT) begin : g_inv
         assign cap = ~wdata;
      end else begin : g_direct
         assign cap = wdata;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                out_q <= '0;
      else if (wr_req && hit_out) out_q <= cap;
   end

   assign out_port = out_q;
endmodule

// File: rtl/oisc_core.sv
module oisc_core #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] in_port,
   output logic [DATA_W-1:0] out_port,
   output logic              halted
);
   import oisc_pkg::*;

   localparam logic [ADDR_W-1:0] HALT_ADDR = '1;

   generate
      if (ADDR_W < DATA_W) begin : g_bad_width
         $error("oisc_core: ADDR_W must not be below DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("oisc_core: DATA_W must be at least 2");
      end
   endgenerate

   oisc_state_e       st_q;
   logic [ADDR_W-1:0] pc_q, a_addr_q, b_addr_q, tgt_q, pc_step, ext;
   logic [DATA_W-1:0] a_val_q, rdata, diff;
   logic              jump_q, gt, wr_req;

   generate
      if (ADDR_W > DATA_W) begin : g_sext
         assign ext = {{(ADDR_W-DATA_W){rdata[DATA_W-1]}}, rdata};
      end else begin : g_same
         assign ext = rdata;
      end
   endgenerate

   oisc_pc_adder #(.ADDR_W(ADDR_W), .STEP(3)) pc_add_i (
      .pc      (pc_q),
      .cin     (1'b1),
      .pc_next (pc_step)
   );

   oisc_subtract #(.DATA_W(DATA_W)) sub_i (
      .minuend    (rdata),
      .subtrahend (a_val_q),
      .diff       (diff),
      .gt         (gt)
   );

   assign wr_req = (st_q == ST_WRITE_B);

   oisc_io_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INVERT_OUT(1'b1)) io_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (mem_addr),
      .wr_req    (wr_req),
      .wdata     (diff),
      .mem_rdata (mem_rdata),
      .in_port   (in_port),
      .mem_we    (mem_we),
      .rdata     (rdata),
      .out_port  (out_port)
   );

   always_comb begin
      unique case (st_q)
         ST_FETCH_A: mem_addr = pc_q;
         ST_FETCH_B: mem_addr = pc_q + ADDR_W'(1);
         ST_FETCH_C: mem_addr = pc_q + ADDR_W'(2);
         ST_READ_A:  mem_addr = a_addr_q;
         ST_READ_B,
         ST_WRITE_B: mem_addr = b_addr_q;
         default:    mem_addr = pc_q;
      endcase
   end

   assign mem_wdata = diff;
   assign halted    = (st_q == ST_HALT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_FETCH_A;
         pc_q     <= '0;
         a_addr_q <= '0;
         b_addr_q <= '0;
         tgt_q    <= '0;
         a_val_q  <= '0;
         jump_q   <= 1'b0;
      end else begin
         unique case (st_q)
            ST_FETCH_A: st_q <= ST_FETCH_B;
            ST_FETCH_B: begin
               a_addr_q <= ext;
               st_q     <= ST_FETCH_C;
            end
            ST_FETCH_C: begin
               b_addr_q <= ext;
               st_q     <= ST_READ_A;
            end
            ST_READ_A: begin
               tgt_q <= ext;
               st_q  <= ST_READ_B;
            end
            ST_READ_B: begin
               a_val_q <= rdata;
               st_q    <= ST_WRITE_B;
            end
            ST_WRITE_B: begin
               jump_q <= ~gt;
               st_q   <= ST_BRANCH;
            end
            ST_BRANCH: begin
               if (jump_q && tgt_q == HALT_ADDR) begin
                  st_q <= ST_HALT;
               end else begin
                  pc_q <= jump_q ? tgt_q : pc_step;
                  st_q <= ST_FETCH_A;
               end
            end
            default: st_q <= ST_HALT;
         endcase
      end
   end
endmodule

// File: rtl/oisc_core_chk.sv
module oisc_core_chk #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     mem_addr,
   input logic                  mem_we,
   input logic [DATA_W-1:0]     out_port,
   input logic                  halted,
   input oisc_pkg::oisc_state_e st
);
   import oisc_pkg::*;
   localparam logic [ADDR_W-1:0] IN_A  = '1;
   localparam logic [ADDR_W-1:0] OUT_A = {{(ADDR_W-1){1'b1}}, 1'b0};

   // R8
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R8
   halt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_we);

   // R6
   no_io_mem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr != IN_A && mem_addr != OUT_A));

   // R9
   single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R9
   write_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> st == ST_WRITE_B);

   // R7
   out_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_port) |-> $past(st == ST_WRITE_B && mem_addr == OUT_A));
endmodule

bind oisc_core oisc_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_addr (mem_addr),
   .mem_we   (mem_we),
   .out_port (out_port),
   .halted   (halted),
   .st       (st_q)
);

// File: tb/oisc_core_tb.sv
module oisc_core_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 12;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata, in_port, out_port;
   logic          mem_we, halted;

   logic [7:0] bmem [256];
   int rm [256];

   int n_chk = 0, n_fail = 0;
   int ph, epc, ra, rb, rc, va, vb, dd, npc, exp_out;
   bit exp_halted, halt_next, exp_we, first_ins;

   always #(CLK_PERIOD/2) clk = ~clk;

   oisc_core #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_we(mem_we), .in_port(in_port),
      .out_port(out_port), .halted(halted)
   );

   always @(posedge clk) begin
      mem_rdata <= bmem[mem_addr[7:0]];
      if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
   end

   function automatic int sx(int w);
      return ((w & 8'h80) != 0) ? ((w | 32'hF00) & 32'hFFF) : (w & 32'hFF);
   endfunction

   function automatic int rdv(int a);
      if (a == 32'hFFF) return int'(in_port);
      if (a == 32'hFFE) return 32'hFF;
      return rm[a & 32'hFF];
   endfunction

   task automatic check(bit ok, string tag, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic put(int a, int w);
      bmem[a] = 8'(w);
      rm[a]   = w & 32'hFF;
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) put(i, 0);
   endtask

   task automatic model_start();
      ph = 0; epc = 0; exp_out = 0; exp_halted = 0; first_ins = 1;
   endtask

   task automatic tick();
      if (exp_halted) begin
         check(halted === 1'b1, "R8 halted held", int'(halted), 1);
         check(mem_we === 1'b0, "R8 no write when halted", int'(mem_we), 0);
         check(int'(out_port) == exp_out, "R8 out frozen", int'(out_port), exp_out);
         return;
      end
      check(halted === 1'b0, "R8 halted low while running", int'(halted), 0);
      if (ph == 0) begin
         ra = sx(rm[epc & 32'hFF]);
         rb = sx(rm[(epc + 1) & 32'hFF]);
         rc = sx(rm[(epc + 2) & 32'hFF]);
         va = rdv(ra);
         vb = rdv(rb);
         dd = (vb - va) & 32'hFF;
         exp_we = (rb != 32'hFFF) && (rb != 32'hFFE);
         npc = (vb > va) ? ((epc + 3) & 32'hFFF) : rc;
         halt_next = !(vb > va) && rc == 32'hFFF;
         check(int'(mem_addr) == epc, first_ins ? "R5 first fetch at PC" : "R4 next PC",
               int'(mem_addr), epc);
      end
      case (ph)
         1: check(int'(mem_addr) == ((epc + 1) & 32'hFFF), "R1 fetch B addr", int'(mem_addr), (epc + 1) & 32'hFFF);
         2: check(int'(mem_addr) == ((epc + 2) & 32'hFFF), "R1 fetch C addr", int'(mem_addr), (epc + 2) & 32'hFFF);
         3: check(int'(mem_addr) == ra, "R2 source addr", int'(mem_addr), ra);
         4: check(int'(mem_addr) == rb, "R2 dest addr", int'(mem_addr), rb);
         5: begin
            check(int'(mem_addr) == rb, "R1 write addr", int'(mem_addr), rb);
            check(mem_we === exp_we, exp_we ? "R9 write strobe" : "R6 R7 io write suppressed",
                  int'(mem_we), int'(exp_we));
            check(int'(mem_wdata) == dd, "R3 difference", int'(mem_wdata), dd);
            if (rb == 32'hFFE) exp_out = (~dd) & 32'hFF;
         end
         6: check(int'(out_port) == exp_out, "R7 output port", int'(out_port), exp_out);
         default: ;
      endcase
      if (ph != 5) check(mem_we === 1'b0, "R9 no write outside phase", int'(mem_we), 0);
      if (ph == 6) begin
         first_ins = 0;
         if (halt_next) exp_halted = 1;
         else epc = npc;
         ph = 0;
      end else begin
         ph++;
      end
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick();
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      in_port = 8'h10;
      clear_mem();
      repeat (3) @(negedge clk);
      // R5 reset state
      check(mem_addr == '0, "R5 reset addr", int'(mem_addr), 0);
      check(mem_we === 1'b0, "R5 reset no write", int'(mem_we), 0);
      check(out_port == '0, "R5 reset out", int'(out_port), 0);
      check(halted === 1'b0, "R5 reset halted", int'(halted), 0);

      // R5 program of zeros loops at 0
      rst_n = 1'b1;
      model_start();
      #1 tick();
      run(40);

      // R5 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(mem_addr == '0, "R5 reset mid-run addr", int'(mem_addr), 0);
      check(mem_we === 1'b0, "R5 reset mid-run write", int'(mem_we), 0);

      clear_mem();
      // 0: out <- ~(0xFF - 0x5A)
      put(0, 8'h10); put(1, 8'hFE); put(2, 8'h03);
      // 3: mem[0x20] -= in_port, advance (R6)
      put(3, 8'hFF); put(4, 8'h20); put(5, 8'h06);
      // 6: equal operands, jump to 12 (R4)
      put(6, 8'h21); put(7, 8'h22); put(8, 8'h0C);
      // 12: borrow, jump to 18 (R4)
      put(12, 8'h23); put(13, 8'h24); put(14, 8'h12);
      // 18: write into input address ignored, jump to 21 (R6)
      put(18, 8'h10); put(19, 8'hFF); put(20, 8'h15);
      // 21: output write and halt together (R7, R8)
      put(21, 8'h28); put(22, 8'hFE); put(23, 8'hFF);
      put(16, 8'h5A); put(32, 8'h30); put(33, 8'h40); put(34, 8'h40);
      put(35, 8'h80); put(36, 8'h01); put(40, 8'hFF);

      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_start();
      #1 tick();
      run(70);
      check(exp_halted == 1'b1, "R8 program reached halt", int'(exp_halted), 1);
      check(bmem[32] == 8'h20, "R6 input subtract stored", int'(bmem[32]), 8'h20);
      check(bmem[36] == 8'h81, "R3 borrow wrap stored", int'(bmem[36]), 8'h81);
      check(out_port == 8'hFF, "R7 final output", int'(out_port), 8'hFF);
      summary();
   end
endmodule